// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the entry step a small RISC core takes when it accepts an exception or an interrupt. Each cycle it looks at the synchronous exception code offered by the pipeline and at the external and timer interrupt request lines. It then decides whether an entry happens and which cause wins. When an entry happens, the block reports it in that same cycle with a strobe, the handler address and a TLB flush pulse. At the following rising edge it stores the return address, a copy of the status register and the rewritten status register.

The return address is the current PC, corrected for two cases. An instruction in a branch delay slot returns to its branch, so 4 is taken off. A system call returns past itself, so 4 is added. The status register is copied before it is rewritten. The rewrite turns off address translation and both interrupt enables and forces supervisor mode. When no entry happens, the status output follows the core's status value one cycle later. The saved return address and the saved status hold their values.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On an entry cycle `entry_valid_o` and `tlb_flush_o` are both 1 in that same cycle, and `new_pc_o` equals the taken cause code shifted left by 8. Outside entry cycles all three are 0.
- R2: On an entry with neither the delay-slot flag nor a system call, `epc_o` holds the current `pc_i` from the next cycle on.
- R3: On an entry with `dslot_i` = 1, `epc_o` becomes `pc_i` - 4 (modulo 2^32). Bit 13 (delay-slot marker) is set in both `esr_o` and `sr_o`, and `dslot_clr_o` pulses for that cycle.
- R4: On entry for a system call (code 12), `epc_o` becomes `pc_i` + 4. A system call that also sits in a delay slot saves `pc_i` unchanged.
- R5: `esr_o` receives the status value before the rewrite: `sr_i`, with bit 13 set when `dslot_i` = 1.
- R6: After an entry, `sr_o` equals the saved status value with these bits cleared: bit 1 (timer enable), bit 2 (interrupt enable), bit 3 (data translation enable) and bit 4 (instruction translation enable). Bit 0 (supervisor) is set. In every cycle without an entry, `sr_o` takes `sr_i` one cycle later, and `epc_o` and `esr_o` keep their values.
- R7: An external interrupt (code 8) is taken only when `sr_i` bit 2 is 1. A timer interrupt (code 5) is taken only when `sr_i` bit 1 is 1.
- R8: When both interrupts are pending and enabled, the timer interrupt is taken.
- R9: A nonzero valid synchronous code on `exc_code_i` is taken in preference to any pending interrupt.
- R10: Code 0 means no synchronous exception. A code of 14 or above raises `err_o` with no entry and no change to `epc_o` or `esr_o`. Code 13 is the highest code that still vectors.
- R11: `exc_ack_o` pulses in a cycle where a synchronous exception is taken, so that the core returns its pending code to none. It stays 0 on interrupt entries.
- R12: After synchronous reset, `epc_o` and `esr_o` are 0 and `sr_o` has only bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 16 | Current status register value |
| dslot_i | input | 1 | Current instruction sits in a branch delay slot |
| exc_code_i | input | 5 | Pending synchronous exception code, 0 for none |
| ext_irq_i | input | 1 | External interrupt request |
| tick_irq_i | input | 1 | Timer interrupt request |
| entry_valid_o | output | 1 | Entry taken this cycle |
| new_pc_o | output | 32 | Handler address for the entry |
| tlb_flush_o | output | 1 | TLB flush request pulse |
| dslot_clr_o | output | 1 | Clear request for the core's delay-slot flag |
| exc_ack_o | output | 1 | Pending synchronous code consumed |
| err_o | output | 1 | Undefined exception code presented |
| epc_o | output | 32 | Saved return address |
| esr_o | output | 16 | Saved status register |
| sr_o | output | 16 | Updated status register |

## Verification
The assertions check on every cycle that the handler address is aligned and matches the timer cause when the timer wins, and that an undefined code never produces an entry. They also check that the rewritten status always has supervisor set with the enables cleared, that the saved status matches the pre-entry value, and that saved state holds between entries. Only the bench scenarios show some behaviours. These are the exact return-address arithmetic for delay slots, system calls and their combination, including wrap below zero. They also cover the precedence of a synchronous code over both interrupts, the boundary between code 13 and code 14, and the masking of each interrupt by its own enable bit.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   // Build a one-hot mask of the given width from a bit index.
   function automatic logic [63:0] bit_mask(input int unsigned idx);
      logic [63:0] m;
      m = '0;
      m[idx] = 1'b1;
      return m;
   endfunction

   // Adjustment applied to the saved PC, chosen from two entry conditions.
   typedef enum logic [1:0] {
      EPC_SAME  = 2'd0,
      EPC_MINUS = 2'd1,
      EPC_PLUS  = 2'd2
   } epc_adj_e;

endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb #(
   parameter int unsigned CODE_W    = 5,
   parameter int unsigned NUM_EXC   = 14,
   parameter int unsigned CODE_TICK = 5,
   parameter int unsigned CODE_EXT  = 8,
   parameter int unsigned SR_W      = 16,
   parameter int unsigned TEE_BIT   = 1,
   parameter int unsigned IEE_BIT   = 2
) (
   input  logic [CODE_W-1:0] exc_code_i,
   input  logic              ext_irq_i,
   input  logic              tick_irq_i,
   input  logic [SR_W-1:0]   sr_i,
   output logic              take_o,
   output logic              sync_o,
   output logic              bad_o,
   output logic [CODE_W-1:0] code_o
);

   localparam logic [CODE_W-1:0] TICK_C = CODE_W'(CODE_TICK);
   localparam logic [CODE_W-1:0] EXT_C  = CODE_W'(CODE_EXT);

   logic sync_req;
   logic code_undef;
   logic tick_ok;
   logic ext_ok;

   assign sync_req   = (exc_code_i != '0);
   assign code_undef = (32'(exc_code_i) >= 32'(NUM_EXC));
   assign tick_ok    = tick_irq_i & sr_i[TEE_BIT];
   assign ext_ok     = ext_irq_i  & sr_i[IEE_BIT];

   // Priority: synchronous code, then timer, then external.
   always_comb begin
      take_o = 1'b0;
      sync_o = 1'b0;
      bad_o  = 1'b0;
      code_o = '0;
      if (sync_req) begin
         if (code_undef) begin
            bad_o = 1'b1;
         end else begin
            take_o = 1'b1;
            sync_o = 1'b1;
            code_o = exc_code_i;
         end
      end else if (tick_ok) begin
         take_o = 1'b1;
         code_o = TICK_C;
      end else if (ext_ok) begin
         take_o = 1'b1;
         code_o = EXT_C;
      end
   end

   // R10: a taken cause always carries a defined, nonzero code
   always_comb begin
      if (take_o) begin
         p_code_defined_r10: assert (code_o != '0 && 32'(code_o) < 32'(NUM_EXC));
      end
   end

endmodule

// File: rtl/exc_epc_unit.sv
module exc_epc_unit
   import exc_entry_pkg::*;
#(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned INSN_BYTES = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            entry_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic            dslot_i,
   input  logic            syscall_i,
   output logic [PC_W-1:0] epc_o
);

   localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

   epc_adj_e        adj;
   logic [PC_W-1:0] epc_next;
   logic [PC_W-1:0] epc_q;

   // Delay slot and system call cancel each other out.
   always_comb begin
      unique case ({dslot_i, syscall_i})
         2'b10:   adj = EPC_MINUS;
         2'b01:   adj = EPC_PLUS;
         default: adj = EPC_SAME;
      endcase
   end

   always_comb begin
      unique case (adj)
         EPC_MINUS: epc_next = pc_i - STEP;
         EPC_PLUS:  epc_next = pc_i + STEP;
         default:   epc_next = pc_i;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         epc_q <= '0;
      end else if (entry_i) begin
         epc_q <= epc_next;
      end
   end

   assign epc_o = epc_q;

   // R2: plain entry saves the current PC
   p_epc_plain_r2: assert property (@(posedge clk) disable iff (rst)
      (entry_i && !dslot_i && !syscall_i) |=> (epc_o == $past(pc_i)));

   // R6: saved PC holds between entries
   p_epc_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !entry_i |=> (epc_o == $past(epc_o)));

endmodule

// File: rtl/exc_sr_unit.sv
module exc_sr_unit
   import exc_entry_pkg::*;
#(
   parameter int unsigned SR_W     = 16,
   parameter int unsigned SM_BIT   = 0,
   parameter int unsigned TEE_BIT  = 1,
   parameter int unsigned IEE_BIT  = 2,
   parameter int unsigned DME_BIT  = 3,
   parameter int unsigned IME_BIT  = 4,
   parameter int unsigned DSX_BIT  = 13
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            entry_i,
   input  logic            dslot_i,
   input  logic [SR_W-1:0] sr_i,
   output logic [SR_W-1:0] sr_o,
   output logic [SR_W-1:0] esr_o
);

   localparam logic [SR_W-1:0] SM_M  = SR_W'(bit_mask(SM_BIT));
   localparam logic [SR_W-1:0] DSX_M = SR_W'(bit_mask(DSX_BIT));
   localparam logic [SR_W-1:0] CLR_M = SR_W'(bit_mask(TEE_BIT) | bit_mask(IEE_BIT) |
                                             bit_mask(DME_BIT) | bit_mask(IME_BIT));

   logic [SR_W-1:0] sr_marked;
   logic [SR_W-1:0] sr_entry;
   logic [SR_W-1:0] sr_q;
   logic [SR_W-1:0] esr_q;

   assign sr_marked = dslot_i ? (sr_i | DSX_M) : sr_i;
   assign sr_entry  = (sr_marked & ~CLR_M) | SM_M;

   always_ff @(posedge clk) begin
      if (rst) begin
         sr_q  <= SM_M;
         esr_q <= '0;
      end else if (entry_i) begin
         sr_q  <= sr_entry;
         esr_q <= sr_marked;
      end else begin
         sr_q  <= sr_i;
      end
   end

   assign sr_o  = sr_q;
   assign esr_o = esr_q;

   // R6: entry forces supervisor and clears every enable
   p_sr_forced_r6: assert property (@(posedge clk) disable iff (rst)
      entry_i |=> (sr_o[SM_BIT] && !sr_o[TEE_BIT] && !sr_o[IEE_BIT] &&
                   !sr_o[DME_BIT] && !sr_o[IME_BIT]));

   // R5: saved status is the pre-rewrite value
   p_esr_copy_r5: assert property (@(posedge clk) disable iff (rst)
      entry_i |=> (esr_o == ($past(sr_i) | ($past(dslot_i) ? DSX_M : '0))));

   // R6: between entries the status tracks the core and the copy holds
   p_sr_track_r6: assert property (@(posedge clk) disable iff (rst)
      !entry_i |=> (sr_o == $past(sr_i) && esr_o == $past(esr_o)));

   // R3: delay-slot entry leaves the marker set
   p_dsx_set_r3: assert property (@(posedge clk) disable iff (rst)
      (entry_i && dslot_i) |=> (sr_o[DSX_BIT] && esr_o[DSX_BIT]));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
   parameter int unsigned PC_W         = 32,
   parameter int unsigned SR_W         = 16,
   parameter int unsigned CODE_W       = 5,
   parameter int unsigned NUM_EXC      = 14,
   parameter int unsigned CODE_TICK    = 5,
   parameter int unsigned CODE_EXT     = 8,
   parameter int unsigned CODE_SYSCALL = 12,
   parameter int unsigned VEC_SHIFT    = 8,
   parameter int unsigned SM_BIT       = 0,
   parameter int unsigned TEE_BIT      = 1,
   parameter int unsigned IEE_BIT      = 2,
   parameter int unsigned DME_BIT      = 3,
   parameter int unsigned IME_BIT      = 4,
   parameter int unsigned DSX_BIT      = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [SR_W-1:0]   sr_i,
   input  logic              dslot_i,
   input  logic [CODE_W-1:0] exc_code_i,
   input  logic              ext_irq_i,
   input  logic              tick_irq_i,
   output logic              entry_valid_o,
   output logic [PC_W-1:0]   new_pc_o,
   output logic              tlb_flush_o,
   output logic              dslot_clr_o,
   output logic              exc_ack_o,
   output logic              err_o,
   output logic [PC_W-1:0]   epc_o,
   output logic [SR_W-1:0]   esr_o,
   output logic [SR_W-1:0]   sr_o
);

   localparam logic [CODE_W-1:0] SYSCALL_C = CODE_W'(CODE_SYSCALL);

   // Elaboration-time parameter checks
   if (NUM_EXC > (1 << CODE_W)) begin : g_chk_codes
      $error("NUM_EXC does not fit in CODE_W bits");
   end
   if (CODE_W + VEC_SHIFT > PC_W) begin : g_chk_vec
      $error("handler vector does not fit in PC_W bits");
   end
   if (SM_BIT >= SR_W || TEE_BIT >= SR_W || IEE_BIT >= SR_W ||
       DME_BIT >= SR_W || IME_BIT >= SR_W || DSX_BIT >= SR_W) begin : g_chk_bits
      $error("status bit position outside SR_W");
   end
   if (CODE_TICK == 0 || CODE_TICK >= NUM_EXC ||
       CODE_EXT == 0 || CODE_EXT >= NUM_EXC ||
       CODE_SYSCALL == 0 || CODE_SYSCALL >= NUM_EXC) begin : g_chk_cause
      $error("interrupt or system-call code outside defined range");
   end

   logic              take;
   logic              sync;
   logic              bad;
   logic [CODE_W-1:0] code;
   logic              syscall;

   exc_cause_arb #(
      .CODE_W   (CODE_W),
      .NUM_EXC  (NUM_EXC),
      .CODE_TICK(CODE_TICK),
      .CODE_EXT (CODE_EXT),
      .SR_W     (SR_W),
      .TEE_BIT  (TEE_BIT),
      .IEE_BIT  (IEE_BIT)
   ) arb_i (
      .exc_code_i(exc_code_i),
      .ext_irq_i (ext_irq_i),
      .tick_irq_i(tick_irq_i),
      .sr_i      (sr_i),
      .take_o    (take),
      .sync_o    (sync),
      .bad_o     (bad),
      .code_o    (code)
   );

   assign syscall = sync && (code == SYSCALL_C);

   exc_epc_unit #(
      .PC_W      (PC_W),
      .INSN_BYTES(4)
   ) epc_i (
      .clk      (clk),
      .rst      (rst),
      .entry_i  (take),
      .pc_i     (pc_i),
      .dslot_i  (dslot_i),
      .syscall_i(syscall),
      .epc_o    (epc_o)
   );

   exc_sr_unit #(
      .SR_W   (SR_W),
      .SM_BIT (SM_BIT),
      .TEE_BIT(TEE_BIT),
      .IEE_BIT(IEE_BIT),
      .DME_BIT(DME_BIT),
      .IME_BIT(IME_BIT),
      .DSX_BIT(DSX_BIT)
   ) sr_i_unit (
      .clk    (clk),
      .rst    (rst),
      .entry_i(take),
      .dslot_i(dslot_i),
      .sr_i   (sr_i),
      .sr_o   (sr_o),
      .esr_o  (esr_o)
   );

   assign entry_valid_o = take;
   assign tlb_flush_o   = take;
   assign new_pc_o      = take ? (PC_W'(code) << VEC_SHIFT) : '0;
   assign dslot_clr_o   = take & dslot_i;
   assign exc_ack_o     = take & sync;
   assign err_o         = bad;

   // R1: handler address aligned and nonzero on entry
   p_vec_aligned_r1: assert property (@(posedge clk) disable iff (rst)
      entry_valid_o |-> (new_pc_o[VEC_SHIFT-1:0] == '0 && new_pc_o != '0));

   // R10: an undefined code never enters
   p_err_no_entry_r10: assert property (@(posedge clk) disable iff (rst)
      err_o |-> (!entry_valid_o && !tlb_flush_o));

   // R8: an enabled timer with no synchronous code wins
   p_tick_wins_r8: assert property (@(posedge clk) disable iff (rst)
      (exc_code_i == '0 && tick_irq_i && sr_i[TEE_BIT]) |->
         (entry_valid_o && new_pc_o == (PC_W'(CODE_TICK) << VEC_SHIFT)));

   // R7: masked interrupts alone never enter
   p_irq_masked_r7: assert property (@(posedge clk) disable iff (rst)
      (exc_code_i == '0 && !(tick_irq_i && sr_i[TEE_BIT]) &&
       !(ext_irq_i && sr_i[IEE_BIT])) |-> !entry_valid_o);

   // R11: acknowledge only on synchronous entries
   p_ack_sync_r11: assert property (@(posedge clk) disable iff (rst)
      exc_ack_o |-> (entry_valid_o && exc_code_i != '0));

endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;

   localparam int unsigned NUM_EXC = 14;
   localparam logic [15:0] SM  = 16'h0001;
   localparam logic [15:0] TEE = 16'h0002;
   localparam logic [15:0] IEE = 16'h0004;
   localparam logic [15:0] DME = 16'h0008;
   localparam logic [15:0] IME = 16'h0010;
   localparam logic [15:0] DSX = 16'h2000;
   localparam logic [15:0] OTHER = 16'h0200;
   localparam logic [15:0] ALL_EN = SM | TEE | IEE | DME | IME | OTHER;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc_i = '0;
   logic [15:0] sr_i = '0;
   logic        dslot_i = 1'b0;
   logic [4:0]  exc_code_i = '0;
   logic        ext_irq_i = 1'b0;
   logic        tick_irq_i = 1'b0;
   logic        entry_valid_o, tlb_flush_o, dslot_clr_o, exc_ack_o, err_o;
   logic [31:0] new_pc_o, epc_o;
   logic [15:0] esr_o, sr_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   exc_entry_ctrl dut_i (
      .clk(clk), .rst(rst), .pc_i(pc_i), .sr_i(sr_i), .dslot_i(dslot_i),
      .exc_code_i(exc_code_i), .ext_irq_i(ext_irq_i), .tick_irq_i(tick_irq_i),
      .entry_valid_o(entry_valid_o), .new_pc_o(new_pc_o), .tlb_flush_o(tlb_flush_o),
      .dslot_clr_o(dslot_clr_o), .exc_ack_o(exc_ack_o), .err_o(err_o),
      .epc_o(epc_o), .esr_o(esr_o), .sr_o(sr_o)
   );

   typedef struct {
      string       req;
      logic        entry;
      logic [31:0] npc;
      logic        dclr;
      logic        ack;
      logic        err;
      logic [31:0] epc;
      logic [15:0] esr;
      logic [15:0] sr;
   } exp_t;

   exp_t        sb_q[$];
   logic [31:0] m_epc = '0;
   logic [15:0] m_esr = '0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Driver: applies one cycle of stimulus and pushes the expected result.
   task automatic drive(input string req, input logic [4:0] code, input logic [31:0] pc,
                        input logic [15:0] sr, input logic ds, input logic ext,
                        input logic tick);
      exp_t e;
      logic [4:0]  taken;
      logic        sync;
      logic [15:0] marked;
      @(negedge clk);
      exc_code_i = code; pc_i = pc; sr_i = sr; dslot_i = ds;
      ext_irq_i = ext; tick_irq_i = tick;
      taken = '0; sync = 1'b0;
      e.req = req; e.err = 1'b0;
      if (code != 0) begin
         if (32'(code) >= NUM_EXC) e.err = 1'b1;
         else begin taken = code; sync = 1'b1; end
      end else if (tick && sr[1]) taken = 5'd5;
      else if (ext && sr[2]) taken = 5'd8;
      e.entry = (taken != 0);
      e.npc   = e.entry ? (32'(taken) << 8) : 32'h0;
      e.dclr  = e.entry && ds;
      e.ack   = e.entry && sync;
      marked  = ds ? (sr | DSX) : sr;
      if (e.entry) begin
         m_epc = pc;
         if (ds) m_epc = m_epc - 32'd4;
         if (sync && code == 5'd12) m_epc = m_epc + 32'd4;
         m_esr = marked;
         e.sr  = (marked & ~(TEE | IEE | DME | IME)) | SM;
      end else begin
         e.sr  = sr;
      end
      e.epc = m_epc;
      e.esr = m_esr;
      sb_q.push_back(e);
   endtask

   // Monitor: compares same-cycle and registered outputs after each edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.req, "entry_valid", 32'(entry_valid_o), 32'(e.entry));
            chk(e.req, "tlb_flush",   32'(tlb_flush_o),   32'(e.entry));
            chk(e.req, "new_pc",      new_pc_o,           e.npc);
            chk(e.req, "dslot_clr",   32'(dslot_clr_o),   32'(e.dclr));
            chk(e.req, "exc_ack",     32'(exc_ack_o),     32'(e.ack));
            chk(e.req, "err",         32'(err_o),         32'(e.err));
            chk(e.req, "epc",         epc_o,              e.epc);
            chk(e.req, "esr",         32'(esr_o),         32'(e.esr));
            chk(e.req, "sr",          32'(sr_o),          32'(e.sr));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R12: reset state
      chk("R12", "epc",   epc_o,             32'h0);
      chk("R12", "esr",   32'(esr_o),        32'h0);
      chk("R12", "sr",    32'(sr_o),         32'(SM));
      chk("R12", "entry", 32'(entry_valid_o), 32'h0);
      @(negedge clk);
      rst = 1'b0;

      drive("R7_ext_on",      5'd0,  32'h0000_1000, ALL_EN,       1'b0, 1'b1, 1'b0); // R1 R2 R5 R6
      drive("R7_ext_masked",  5'd0,  32'h0000_1100, SM | OTHER,   1'b0, 1'b1, 1'b0);
      drive("R7_tick_on",     5'd0,  32'h0000_1200, SM | TEE,     1'b0, 1'b0, 1'b1);
      drive("R7_tick_masked", 5'd0,  32'h0000_1300, SM | IEE,     1'b0, 1'b1, 1'b1);
      drive("R8_both",        5'd0,  32'h0000_1400, ALL_EN,       1'b0, 1'b1, 1'b1);
      drive("R9_sync_first",  5'd3,  32'h0000_1500, ALL_EN,       1'b0, 1'b1, 1'b1); // R11
      drive("R4_syscall",     5'd12, 32'h0000_2000, ALL_EN,       1'b0, 1'b0, 1'b0);
      drive("R3_dslot",       5'd0,  32'h0000_3000, ALL_EN,       1'b1, 1'b1, 1'b0);
      drive("R4_dslot_sysc",  5'd12, 32'h0000_4000, SM | IEE,     1'b1, 1'b0, 1'b0); // R3
      drive("R10_undef",      5'd14, 32'h0000_5000, ALL_EN,       1'b0, 1'b1, 1'b1);
      drive("R10_undef_top",  5'd31, 32'h0000_5100, TEE,          1'b0, 1'b0, 1'b1);
      drive("R10_max_valid",  5'd13, 32'h0000_6000, OTHER,        1'b0, 1'b0, 1'b0); // R1
      drive("R6_idle",        5'd0,  32'h0000_7000, ALL_EN,       1'b0, 1'b0, 1'b0);
      drive("R3_wrap",        5'd2,  32'h0000_0000, SM,           1'b1, 1'b0, 1'b0);
      drive("R6_idle_hold",   5'd0,  32'h0000_8000, IME | DME,    1'b0, 1'b0, 1'b0);

      @(negedge clk);
      exc_code_i = '0; ext_irq_i = 1'b0; tick_irq_i = 1'b0; dslot_i = 1'b0;
      while (sb_q.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule